// File: doc/BRIEF.md
# Ingress Data Retimer with Frame-Pulse Generator

This block sits at the input edge of a time-slot switching fabric. It samples two parallel byte-wide buses, an upper one and a lower one, on the system clock. It hands the sampled bytes to the switching logic through a capture register. It also re-drives copies of both buses on a pair of pass-through buses, so that several fabrics can be chained in an array. The pass-through copies always trail the inputs by a fixed five-cycle retiming pipeline.

When fabrics are chained, each one needs its data staggered against its neighbour. For this, a single programmable delay of 0, 5, 10 or 15 cycles can be placed on one of two sides of the retiming pipeline. Placed ahead of the capture register, it delays the data seen by the switching logic as well. Placed behind the pipeline, it delays only the pass-through buses. A strap turns the pass-through buses off when no chaining is used. The block then drops their enable and holds them at zero.

The block also derives two frame pulses from a system sync input. One marks the start of the incoming frame and one marks the start of the outgoing frame. The outgoing pulse trails the incoming one by the switching latency. A strap selects which of the two pulses falls in the same cycle as the sync. The sync must arrive once per frame. If it stays away for longer than one frame plus a margin, a loss flag rises and both pulses are held low until the sync returns.

Top module: `ingress_retimer`

## Requirements
- R1: While reset is held and after it is released, both capture outputs and both pass-through buses read zero, `sync_lost` is high and both frame pulses stay low until the first sync.
- R2: A byte presented on `top_in` (or `bot_in`) during cycle k appears on `top_sys` (or `bot_sys`) in cycle k+5+D, where D is the extra delay; the upper and lower lanes never mix.
- R3: `dly_sel` encodes the extra delay D as 0→0, 1→5, 2→10, 3→15 cycles.
- R4: With `dly_post`=0 the extra delay sits ahead of capture, so `top_cap`/`bot_cap` show the cycle-k byte in cycle k+1+D. With `dly_post`=1 the delay sits after the pipeline and the capture outputs show it in cycle k+1 whatever D is.
- R5: With `cascade_off`=1, `sys_oe` is low and `top_sys`/`bot_sys` read zero, while the capture outputs keep their normal timing. With `cascade_off`=0, `sys_oe` is high.
- R6: With `out_align`=0, `in_fp` is high in the cycle `sys_sync` is high and `out_fp` rises SW_LAT cycles later. With `out_align`=1, `out_fp` is high in the sync cycle and `in_fp` rises FRAME_LEN−SW_LAT cycles later.
- R7: Each pulse repeats every FRAME_LEN cycles counted from the most recent sync. A sync that arrives early restarts the frame phase at zero in its own cycle.
- R8: If no sync arrives for FRAME_LEN+MARGIN cycles, `sync_lost` is high from cycle s+FRAME_LEN+MARGIN, where s is the last sync cycle. While it is high both pulses stay low, except in a cycle that itself carries a sync. The next sync clears the flag from the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| top_in | input | W | Upper input byte bus |
| bot_in | input | W | Lower input byte bus |
| dly_sel | input | 2 | Extra delay code (0,5,10,15 cycles) |
| dly_post | input | 1 | 0: delay ahead of capture, 1: delay after pipeline |
| cascade_off | input | 1 | Strap: 1 turns the pass-through buses off |
| out_align | input | 1 | Strap: 0 aligns the incoming pulse to sync, 1 the outgoing pulse |
| sys_sync | input | 1 | System frame sync, one cycle per frame |
| top_cap | output | W | Captured upper byte toward the switching logic |
| bot_cap | output | W | Captured lower byte toward the switching logic |
| top_sys | output | W | Delayed upper pass-through bus |
| bot_sys | output | W | Delayed lower pass-through bus |
| sys_oe | output | 1 | Pass-through bus enable |
| in_fp | output | 1 | Incoming frame pulse |
| out_fp | output | 1 | Outgoing frame pulse |
| sync_lost | output | 1 | High while the sync is missing |

## Verification
The bench drives a fresh random byte on each lane every cycle and keeps a history indexed by cycle. Outputs are read at the falling edge. There the capture outputs must hold the byte of cycle n−1−D (or n−1 when the delay sits after the pipeline), and the pass-through buses the byte of cycle n−5−D. Because the frame pulses respond to the sync within its own cycle, they are sampled a moment after the sync is driven. Each later cycle i after the sync is then compared against the offsets 0, SW_LAT, FRAME_LEN−SW_LAT and FRAME_LEN. The loss flag is expected to rise exactly in cycle FRAME_LEN+MARGIN and not one cycle before.

// File: rtl/ingress_retimer.sv
module ingress_retimer #(
  parameter int W         = 8,
  parameter int STEP      = 5,
  parameter int TAPS      = 3,
  parameter int FRAME_LEN = 6480,
  parameter int SW_LAT    = 270,
  parameter int MARGIN    = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] top_in,
  input  logic [W-1:0] bot_in,
  input  logic [1:0]   dly_sel,
  input  logic         dly_post,
  input  logic         cascade_off,
  input  logic         out_align,
  input  logic         sys_sync,
  output logic [W-1:0] top_cap,
  output logic [W-1:0] bot_cap,
  output logic [W-1:0] top_sys,
  output logic [W-1:0] bot_sys,
  output logic         sys_oe,
  output logic         in_fp,
  output logic         out_fp,
  output logic         sync_lost
);
  localparam int DW    = 2 * W;
  localparam int DEPTH = STEP * TAPS;
  localparam int LIMIT = FRAME_LEN + MARGIN;
  localparam int PW    = $clog2(LIMIT + 1);
  localparam int IN_OFS = FRAME_LEN - SW_LAT;

  logic [DW-1:0] din, dl_in, dl_out, cap_in, sys_data;
  logic [DW-1:0] pipe [STEP];
  logic [DW-1:0] line [DEPTH];

  assign din    = {top_in, bot_in};
  assign dl_in  = dly_post ? pipe[STEP-1] : din;
  assign cap_in = dly_post ? din : dl_out;

  always_comb begin
    dl_out = dl_in;
    for (int k = 1; k <= TAPS; k++)
      if (dly_sel == 2'(k)) dl_out = line[k*STEP-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) line[i] <= '0;
      for (int i = 0; i < STEP; i++) pipe[i] <= '0;
    end else begin
      line[0] <= dl_in;
      for (int i = 1; i < DEPTH; i++) line[i] <= line[i-1];
      pipe[0] <= cap_in;
      for (int i = 1; i < STEP; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign sys_data           = dly_post ? dl_out : pipe[STEP-1];
  assign {top_cap, bot_cap} = pipe[0];
  assign sys_oe             = ~cascade_off;
  assign {top_sys, bot_sys} = sys_oe ? sys_data : '0;

  logic [PW-1:0] ph, wd, phase_now, in_pos, out_pos;
  logic live;

  assign phase_now = sys_sync ? '0 : ph;
  assign live      = sys_sync | ~sync_lost;
  assign in_pos    = out_align ? PW'(IN_OFS) : '0;
  assign out_pos   = out_align ? '0 : PW'(SW_LAT);
  assign in_fp     = live && (phase_now == in_pos);
  assign out_fp    = live && (phase_now == out_pos);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= '0;
      wd        <= '0;
      sync_lost <= 1'b1;
    end else begin
      if (sys_sync)                      ph <= PW'(1);
      else if (ph == PW'(FRAME_LEN - 1)) ph <= '0;
      else                               ph <= ph + 1'b1;
      if (sys_sync)               wd <= PW'(1);
      else if (wd != PW'(LIMIT))  wd <= wd + 1'b1;
      if (sys_sync)                   sync_lost <= 1'b0;
      else if (wd == PW'(LIMIT - 1))  sync_lost <= 1'b1;
    end
  end

  initial begin
    assert_lat_fits_R6: assert (SW_LAT > 0 && SW_LAT < FRAME_LEN);
  end

  assert_post_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dly_post |=> {top_cap, bot_cap} == $past({top_in, bot_in}));

  assert_in_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_sync && !out_align) |-> (in_fp && !out_fp));

  assert_out_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_sync && out_align) |-> (out_fp && !in_fp));

  assert_lost_gates_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_lost && !sys_sync) |-> (!in_fp && !out_fp));

  assert_sync_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sys_sync |=> !sync_lost);

  assert_bus_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cascade_off |-> (top_sys == '0 && bot_sys == '0));

  assert_pulse_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fp && !sys_sync && !out_align) |-> $past(sys_sync) == 1'b0);
endmodule

// File: tb/ingress_retimer_bench.sv
module ingress_retimer_bench;
  localparam int F = 100, LAT = 27, M = 8;

  logic clk = 0, rst_n = 0;
  logic [7:0] top_in = 0, bot_in = 0;
  logic [1:0] dly_sel = 0;
  logic dly_post = 0, cascade_off = 0, out_align = 0, sys_sync = 0;
  logic [7:0] top_cap, bot_cap, top_sys, bot_sys;
  logic sys_oe, in_fp, out_fp, sync_lost;

  int checks = 0, fails = 0, n = 0;
  logic [15:0] hist [256];
  bit timeout = 0;

  always #2 clk = ~clk;

  ingress_retimer #(.W(8), .STEP(5), .TAPS(3), .FRAME_LEN(F), .SW_LAT(LAT), .MARGIN(M)) u_ingress_retimer (
    .clk, .rst_n, .top_in, .bot_in, .dly_sel, .dly_post, .cascade_off, .out_align,
    .sys_sync, .top_cap, .bot_cap, .top_sys, .bot_sys, .sys_oe, .in_fp, .out_fp, .sync_lost);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic drive_next();
    logic [15:0] v;
    v = 16'($urandom);
    hist[n[7:0]] = v;
    {top_in, bot_in} = v;
    n++;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk({top_cap, bot_cap, top_sys, bot_sys} == 0, "R1 outputs in reset", {top_cap, bot_cap}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(sync_lost == 1, "R1 sync_lost after reset", sync_lost, 1);
    chk(in_fp == 0 && out_fp == 0, "R1 pulses idle", {in_fp, out_fp}, 0);
    chk({top_sys, bot_sys} == 0, "R1 pass-through zero", {top_sys, bot_sys}, 0);
  endtask

  task automatic t_data(input bit post, input logic [1:0] sel, input bit off, input string tag);
    int d, cap_lat;
    logic [15:0] exp_sys, exp_cap;
    @(negedge clk);
    dly_post = post; dly_sel = sel; cascade_off = off;
    drive_next();
    d = 5 * int'(sel);
    cap_lat = post ? 1 : 1 + d;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (i >= 30) begin
        exp_cap = hist[8'(n - cap_lat)];
        exp_sys = off ? 16'h0 : hist[8'(n - 5 - d)];
        chk({top_cap, bot_cap} == exp_cap, {tag, " R4 capture latency"}, {top_cap, bot_cap}, exp_cap);
        chk({top_sys, bot_sys} == exp_sys, {tag, " R2 R3 pass-through latency"}, {top_sys, bot_sys}, exp_sys);
        chk(sys_oe == !off, {tag, " R5 enable"}, sys_oe, !off);
      end
      drive_next();
    end
  endtask

  task automatic fire_sync();
    @(negedge clk);
    sys_sync = 1;
    #1;
  endtask

  task automatic t_frame(input bit align);
    bit e_in, e_out;
    @(negedge clk);
    out_align = align;
    fire_sync();
    chk(align ? (out_fp && !in_fp) : (in_fp && !out_fp), "R6 pulse coincident with sync", {in_fp, out_fp}, align ? 1 : 2);
    for (int i = 1; i <= F + M + 2; i++) begin
      @(negedge clk);
      sys_sync = 0;
      #1;
      if (align) begin
        e_out = (i == F);
        e_in  = (i == F - LAT);
      end else begin
        e_in  = (i == F);
        e_out = (i == LAT);
      end
      chk(in_fp == e_in, "R6 R7 in_fp timing", in_fp, e_in);
      chk(out_fp == e_out, "R6 R7 out_fp timing", out_fp, e_out);
      chk(sync_lost == (i >= F + M), "R8 loss flag timing", sync_lost, (i >= F + M));
    end
  endtask

  task automatic t_resync();
    bit e_in, e_out;
    @(negedge clk);
    out_align = 0;
    fire_sync();
    for (int i = 1; i < 40; i++) begin
      @(negedge clk);
      sys_sync = 0;
    end
    fire_sync();
    chk(in_fp == 1, "R7 early sync restarts phase", in_fp, 1);
    for (int i = 1; i <= F + M - 2; i++) begin
      @(negedge clk);
      sys_sync = 0;
      #1;
      e_in  = (i == F);
      e_out = (i == LAT);
      chk(in_fp == e_in, "R7 in_fp after resync", in_fp, e_in);
      chk(out_fp == e_out, "R7 out_fp after resync", out_fp, e_out);
      chk(sync_lost == 0, "R8 flag clear after resync", sync_lost, 0);
    end
  endtask

  task automatic run_all();
    t_reset();
    for (int p = 0; p < 2; p++)
      for (int s = 0; s < 4; s++)
        t_data(p[0], 2'(s), 1'b0, $sformatf("post=%0d sel=%0d", p, s));
    t_data(1'b0, 2'd0, 1'b1, "R5 cascade off");
    t_data(1'b1, 2'd2, 1'b1, "R5 cascade off post");
    t_frame(1'b0);
    t_frame(1'b1);
    t_resync();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        timeout = 1;
      end
    join_any
    if (timeout) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule